// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

This block turns a stream of one-byte commands from a host byte link into read and write accesses on an 8-bit-addressed register space. The high nibble of each byte selects an operation and the low nibble carries a four-bit operand. A full register address is assembled from two nibble loads. A full data byte is likewise assembled from a low-nibble load followed by a high-nibble command, and that second command commits the write. A read command returns the byte at the current address on a registered output with a one-cycle valid pulse. Write and read commands can step the address up or down by one after the access, so block transfers need no fresh address loads.

The lowest `CORE_REGS` addresses belong to function registers outside this block. Their writes leave through the write strobe port, and their read values come in through a separate read port, because one address may mean different things for a read and for a write. With `GP_STORE` set, the remaining addresses are backed by storage inside the block. Opcodes reserved for sample-memory transfers are not executed and are reported on a one-cycle flag.

Top module: `nib_cmd_regport`

## Requirements
- R1: A synchronous reset sets the address register and the pending data nibble to zero and holds `wr_stb`, `rd_valid` and `unsup_stb` low. The first write after reset therefore goes to address 0x00, with the operand in bits [7:4] of the data and zero in bits [3:0].
- R2: Opcode 0x0 (bits [7:4] of the command) copies the operand into address bits [3:0]. Opcode 0x1 copies it into address bits [7:4]. Neither changes the other address nibble, and neither produces a strobe.
- R3: Opcode 0x2 stores the operand as the pending low data nibble and does not write. Opcode 0x3 writes {operand, pending nibble} to the current address. `wr_stb` is high for exactly the one cycle after the command is accepted, and `wr_addr`/`wr_data` are valid in that cycle. The pending nibble is kept after the write.
- R4: Opcode 0x4 returns the byte at the current address on `rd_data`. `rd_valid` is high for exactly the one cycle after the command is accepted.
- R5: For opcodes 0x3 and 0x4 only, operand bit 0 set moves the address by one after the access. Operand bit 1 chooses the direction (1 = down, 0 = up). With bit 0 clear the address stays where it is, whatever bit 1 holds. Opcode 0x2 never moves the address.
- R6: Address stepping wraps modulo 256: up from 0xFF gives 0x00, and down from 0x00 gives 0xFF.
- R7: Reads at addresses 0x10 to 0xFF return the byte last written there. Reads at addresses 0x00 to 0x0F return `ext_rd_data` for `ext_rd_addr` equal to the current address, and a write to such an address does not change what is read back there.
- R8: Opcodes 0x5 to 0xB raise `unsup_stb` for one cycle. Opcodes 0x5 to 0xF change neither the address nor the pending nibble and produce no write or read strobe.
- R9: A byte presented while `cmd_valid` is low has no effect on any output or on any internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Qualifies `cmd_byte` for one cycle |
| cmd_byte | input | 8 | Command: opcode in [7:4], operand in [3:0] |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Address of the write |
| wr_data | output | 8 | Data of the write |
| ext_rd_addr | output | 8 | Current address, for the external core read mux |
| ext_rd_data | input | 8 | Read value of the core registers at `ext_rd_addr` |
| rd_valid | output | 1 | One-cycle read-data valid strobe |
| rd_data | output | 8 | Returned read byte |
| unsup_stb | output | 1 | One-cycle flag for an unsupported transfer opcode |

## Verification
A table of command bytes walks through several patterns. There are write-then-read pairs at a storage address with the address stepped up, stepped down and held, which separates the two direction bits and shows that bit 1 alone does nothing. There is a write followed by a read at a core address, which shows that read and write paths are separate there. There are writes and reads that step across 0xFF/0x00, which exposes a wrap error. Unsupported and unassigned opcodes are placed between known reads and writes, so any change they make to the address or the pending nibble shows up in the next returned byte. Directed tests cover the reset state, a reset in the middle of a stream, and a byte held while `cmd_valid` is low.

// File: rtl/nib_cmd_pkg.sv
`timescale 1ns/1ps
package nib_cmd_pkg;

   // Opcode values carried in the upper nibble of a command byte
   localparam logic [3:0] OP_ADDR_LO  = 4'h0;
   localparam logic [3:0] OP_ADDR_HI  = 4'h1;
   localparam logic [3:0] OP_DATA_LO  = 4'h2;
   localparam logic [3:0] OP_DATA_WR  = 4'h3;
   localparam logic [3:0] OP_READ     = 4'h4;

   // Operand bit positions for access commands
   localparam int OPND_ADJ_BIT = 0;
   localparam int OPND_DN_BIT  = 1;

   // One-hot-ish action bundle produced by the decoder
   typedef struct packed {
      logic ld_alo;
      logic ld_ahi;
      logic ld_dlo;
      logic wr;
      logic rd;
      logic adj;
      logic dn;
      logic unsup;
   } nib_act_t;

endpackage

// File: rtl/nib_cmd_decode.sv
`timescale 1ns/1ps
module nib_cmd_decode
   import nib_cmd_pkg::*;
#(
   parameter int NIB_W    = 4,
   parameter int UNSUP_LO = 5,
   parameter int UNSUP_HI = 11
) (
   input  logic               cmd_valid,
   input  logic [2*NIB_W-1:0] cmd_byte,
   output nib_act_t           act,
   output logic [NIB_W-1:0]   operand
);
   logic [NIB_W-1:0] op;
   logic             access;

   assign op      = cmd_byte[2*NIB_W-1:NIB_W];
   assign operand = cmd_byte[NIB_W-1:0];

   always_comb begin
      act        = '0;
      act.ld_alo = cmd_valid && (op == NIB_W'(OP_ADDR_LO));
      act.ld_ahi = cmd_valid && (op == NIB_W'(OP_ADDR_HI));
      act.ld_dlo = cmd_valid && (op == NIB_W'(OP_DATA_LO));
      act.wr     = cmd_valid && (op == NIB_W'(OP_DATA_WR));
      act.rd     = cmd_valid && (op == NIB_W'(OP_READ));
      act.unsup  = cmd_valid && (int'(op) >= UNSUP_LO) && (int'(op) <= UNSUP_HI);
      access     = act.wr || act.rd;
      act.adj    = access && operand[OPND_ADJ_BIT];
      act.dn     = access && operand[OPND_DN_BIT];
   end

   // R8: decoded transfer opcodes never overlap executed ones
   always_comb begin
      a_r8_unsup_exclusive: assert (!(act.unsup && (act.wr || act.rd || act.ld_alo
                                    || act.ld_ahi || act.ld_dlo)));
   end

endmodule

// File: rtl/nib_addr_unit.sv
`timescale 1ns/1ps
module nib_addr_unit #(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ld_lo,
   input  logic               ld_hi,
   input  logic               adj,
   input  logic               dn,
   input  logic [NIB_W-1:0]   nib,
   output logic [2*NIB_W-1:0] addr_q
);
   localparam int AW = 2 * NIB_W;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
      end else if (ld_lo) begin
         addr_q[NIB_W-1:0] <= nib;
      end else if (ld_hi) begin
         addr_q[AW-1:NIB_W] <= nib;
      end else if (adj) begin
         addr_q <= dn ? addr_q - 1'b1 : addr_q + 1'b1;
      end
   end

   // R5 / R6: stepping moves by exactly one, modulo the address space
   a_r5_step_up: assert property (@(posedge clk) disable iff (rst)
      (adj && !dn) |=> (addr_q == AW'($past(addr_q) + 1'b1)));
   a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
      (adj && dn) |=> (addr_q == AW'($past(addr_q) - 1'b1)));
   a_r6_wrap_up: assert property (@(posedge clk) disable iff (rst)
      (adj && !dn && (&addr_q)) |=> (addr_q == '0));
   // R2: a nibble load leaves the other nibble untouched
   a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
      ld_lo |=> $stable(addr_q[AW-1:NIB_W]));
   a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
      ld_hi |=> $stable(addr_q[NIB_W-1:0]));

endmodule

// File: rtl/nib_gp_store.sv
`timescale 1ns/1ps
module nib_gp_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int BASE   = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic              hit,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = (1 << ADDR_W) - BASE;
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [IW-1:0]     widx, ridx;
   logic              whit;

   assign whit = (int'(waddr) >= BASE);
   assign hit  = (int'(raddr) >= BASE);
   assign widx = IW'(waddr - ADDR_W'(BASE));
   assign ridx = IW'(raddr - ADDR_W'(BASE));

   always_ff @(posedge clk) begin
      if (we && whit) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = hit ? mem[ridx] : '0;

endmodule

// File: rtl/nib_cmd_regport.sv
`timescale 1ns/1ps
module nib_cmd_regport
   import nib_cmd_pkg::*;
#(
   parameter int CMD_W     = 8,
   parameter int CORE_REGS = 16,
   parameter bit GP_STORE  = 1'b1,
   parameter int UNSUP_LO  = 5,
   parameter int UNSUP_HI  = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_byte,
   output logic             wr_stb,
   output logic [CMD_W-1:0] wr_addr,
   output logic [CMD_W-1:0] wr_data,
   output logic [CMD_W-1:0] ext_rd_addr,
   input  logic [CMD_W-1:0] ext_rd_data,
   output logic             rd_valid,
   output logic [CMD_W-1:0] rd_data,
   output logic             unsup_stb
);
   localparam int NIB_W  = CMD_W / 2;
   localparam int ADDR_W = 2 * NIB_W;
   localparam int SPACE  = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (CMD_W % 2 != 0) begin : g_bad_width
      $error("nib_cmd_regport: CMD_W must be even");
   end
   if (CORE_REGS < 1 || CORE_REGS >= SPACE) begin : g_bad_core
      $error("nib_cmd_regport: CORE_REGS must lie inside the address space");
   end
   if (UNSUP_LO <= int'(OP_READ) || UNSUP_HI >= (1 << NIB_W) || UNSUP_LO > UNSUP_HI) begin : g_bad_unsup
      $error("nib_cmd_regport: unsupported opcode range is invalid");
   end

   nib_act_t          act;
   logic [NIB_W-1:0]  operand;
   logic [ADDR_W-1:0] addr_q;
   logic [NIB_W-1:0]  pend_q;
   logic [CMD_W-1:0]  rd_byte;
   logic [CMD_W-1:0]  gp_q;
   logic              gp_hit;

   nib_cmd_decode #(
      .NIB_W    (NIB_W),
      .UNSUP_LO (UNSUP_LO),
      .UNSUP_HI (UNSUP_HI)
   ) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .act       (act),
      .operand   (operand)
   );

   nib_addr_unit #(
      .NIB_W (NIB_W)
   ) u_addr (
      .clk    (clk),
      .rst    (rst),
      .ld_lo  (act.ld_alo),
      .ld_hi  (act.ld_ahi),
      .adj    (act.adj),
      .dn     (act.dn),
      .nib    (operand),
      .addr_q (addr_q)
   );

   assign ext_rd_addr = addr_q;

   // Storage for the general-purpose address range, or none at all
   if (GP_STORE) begin : g_store
      nib_gp_store #(
         .ADDR_W (ADDR_W),
         .DATA_W (CMD_W),
         .BASE   (CORE_REGS)
      ) u_store (
         .clk   (clk),
         .we    (act.wr),
         .waddr (addr_q),
         .wdata ({operand, pend_q}),
         .raddr (addr_q),
         .hit   (gp_hit),
         .rdata (gp_q)
      );
   end else begin : g_no_store
      assign gp_hit = 1'b0;
      assign gp_q   = '0;
   end

   // Read mux is independent of the write decode
   assign rd_byte = gp_hit ? gp_q : ext_rd_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q    <= '0;
         wr_stb    <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         unsup_stb <= 1'b0;
      end else begin
         wr_stb    <= act.wr;
         rd_valid  <= act.rd;
         unsup_stb <= act.unsup;
         if (act.ld_dlo) begin
            pend_q <= operand;
         end
         if (act.wr) begin
            wr_addr <= addr_q;
            wr_data <= {operand, pend_q};
         end
         if (act.rd) begin
            rd_data <= rd_byte;
         end
      end
   end

   // R3: a strobe follows only the committing high-nibble command
   a_r3_wr_only_on_commit: assert property (@(posedge clk) disable iff (rst)
      !(cmd_valid && (cmd_byte[CMD_W-1:NIB_W] == NIB_W'(OP_DATA_WR))) |=> !wr_stb);
   a_r3_wr_addr_is_current: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && (cmd_byte[CMD_W-1:NIB_W] == NIB_W'(OP_DATA_WR)))
      |=> (wr_stb && (wr_addr == $past(ext_rd_addr))));
   // R4: read valid lasts one cycle per read command
   a_r4_rd_pulse: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && (cmd_byte[CMD_W-1:NIB_W] == NIB_W'(OP_READ))) |=> rd_valid);
   a_r4_rd_only_on_read: assert property (@(posedge clk) disable iff (rst)
      !(cmd_valid && (cmd_byte[CMD_W-1:NIB_W] == NIB_W'(OP_READ))) |=> !rd_valid);
   // R8: a flagged opcode leaves address and pending nibble alone
   a_r8_unsup_no_change: assert property (@(posedge clk) disable iff (rst)
      act.unsup |=> (unsup_stb && $stable(addr_q) && $stable(pend_q)));
   // R9: an idle cycle changes nothing
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |=> (!wr_stb && !rd_valid && !unsup_stb
                      && $stable(addr_q) && $stable(pend_q)));
   // R1: strobes are mutually exclusive
   a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
      $onehot0({wr_stb, rd_valid, unsup_stb}));

endmodule

// File: tb/nib_cmd_regport_test.sv
`timescale 1ns/1ps
module nib_cmd_regport_test;

   typedef struct packed {
      logic [3:0] tag;
      logic [7:0] cmd;
      logic       ew;
      logic [7:0] wa;
      logic [7:0] wd;
      logic       er;
      logic [7:0] rd;
      logic       eu;
   } vec_t;

   function automatic vec_t mk(input int tag, input logic [7:0] cmd,
                               input logic ew, input logic [7:0] wa, input logic [7:0] wd,
                               input logic er, input logic [7:0] rd, input logic eu);
      vec_t v;
      v.tag = 4'(tag); v.cmd = cmd; v.ew = ew; v.wa = wa; v.wd = wd;
      v.er = er; v.rd = rd; v.eu = eu;
      return v;
   endfunction

   localparam int NV = 34;
   // Starts from reset state: address 0x00, pending nibble 0
   localparam vec_t VEC [NV] = '{
      mk(1, 8'h35, 1, 8'h00, 8'h50, 0, 8'h00, 0), // R1 first write after reset
      mk(2, 8'h0C, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R2 low address nibble
      mk(2, 8'h12, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R2 high nibble -> 0x2C
      mk(3, 8'h27, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R3 pending 7, no write
      mk(5, 8'h31, 1, 8'h2C, 8'h17, 0, 8'h00, 0), // R5 write, step up -> 2D
      mk(3, 8'h2A, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R3 pending A
      mk(5, 8'h3B, 1, 8'h2D, 8'hBA, 0, 8'h00, 0), // R5 write, step down -> 2C
      mk(7, 8'h41, 0, 8'h00, 8'h00, 1, 8'h17, 0), // R7 read back, up -> 2D
      mk(5, 8'h43, 0, 8'h00, 8'h00, 1, 8'hBA, 0), // R5 read, down -> 2C
      mk(4, 8'h40, 0, 8'h00, 8'h00, 1, 8'h17, 0), // R4 read, hold
      mk(5, 8'h42, 0, 8'h00, 8'h00, 1, 8'h17, 0), // R5 direction bit alone: hold
      mk(5, 8'h40, 0, 8'h00, 8'h00, 1, 8'h17, 0), // R5 still at 2C
      mk(2, 8'h03, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R2
      mk(2, 8'h10, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R2 address 0x03
      mk(7, 8'h40, 0, 8'h00, 8'h00, 1, 8'hA6, 0), // R7 core read = addr ^ A5
      mk(3, 8'h2F, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R3 pending F
      mk(3, 8'h30, 1, 8'h03, 8'h0F, 0, 8'h00, 0), // R3 core write
      mk(7, 8'h40, 0, 8'h00, 8'h00, 1, 8'hA6, 0), // R7 write did not alter read
      mk(2, 8'h0F, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R2
      mk(2, 8'h1F, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R2 address 0xFF
      mk(3, 8'h2E, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R3 pending E
      mk(6, 8'h31, 1, 8'hFF, 8'h1E, 0, 8'h00, 0), // R6 write FF, wrap up -> 00
      mk(6, 8'h40, 0, 8'h00, 8'h00, 1, 8'hA5, 0), // R6 now at 00
      mk(6, 8'h43, 0, 8'h00, 8'h00, 1, 8'hA5, 0), // R6 read 00, wrap down -> FF
      mk(6, 8'h40, 0, 8'h00, 8'h00, 1, 8'h1E, 0), // R6 back at FF
      mk(8, 8'h55, 0, 8'h00, 8'h00, 0, 8'h00, 1), // R8 flagged
      mk(8, 8'hA3, 0, 8'h00, 8'h00, 0, 8'h00, 1), // R8 flagged
      mk(8, 8'hC1, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R8 ignored silently
      mk(8, 8'hF3, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R8 ignored silently
      mk(8, 8'h40, 0, 8'h00, 8'h00, 1, 8'h1E, 0), // R8 address unchanged
      mk(8, 8'h34, 1, 8'hFF, 8'h4E, 0, 8'h00, 0), // R8 pending E kept
      mk(8, 8'h40, 0, 8'h00, 8'h00, 1, 8'h4E, 0), // R8 read new value
      mk(5, 8'h21, 0, 8'h00, 8'h00, 0, 8'h00, 0), // R5 opcode 2 never steps
      mk(5, 8'h40, 0, 8'h00, 8'h00, 1, 8'h4E, 0)  // R5 still at FF
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       wr_stb, rd_valid, unsup_stb;
   logic [7:0] wr_addr, wr_data, ext_rd_addr, ext_rd_data, rd_data;
   int         n_chk = 0;
   int         n_bad = 0;

   always #2.5 clk = ~clk;

   // Core registers modelled as a fixed function of the address
   assign ext_rd_data = ext_rd_addr ^ 8'hA5;

   nib_cmd_regport uut (
      .clk         (clk),
      .rst         (rst),
      .cmd_valid   (cmd_valid),
      .cmd_byte    (cmd_byte),
      .wr_stb      (wr_stb),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .ext_rd_addr (ext_rd_addr),
      .ext_rd_data (ext_rd_data),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .unsup_stb   (unsup_stb)
   );

   task automatic check(input int tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic apply(input logic [7:0] c, input logic v);
      cmd_byte  = c;
      cmd_valid = v;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state of the strobes
      check(1, "strobes in reset", {29'd0, wr_stb, rd_valid, unsup_stb}, 32'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].cmd, 1'b1);
         check(int'(VEC[i].tag), $sformatf("vec %0d outputs", i),
               {13'd0, wr_stb, (wr_stb ? wr_addr : 8'h00), (wr_stb ? wr_data : 8'h00),
                rd_valid, (rd_valid ? rd_data : 8'h00), unsup_stb},
               {13'd0, VEC[i].ew, VEC[i].wa, VEC[i].wd, VEC[i].er, VEC[i].rd, VEC[i].eu});
      end

      // R9: commands without cmd_valid have no effect
      apply(8'h35, 1'b0);
      check(9, "no strobe while idle", {30'd0, wr_stb, rd_valid}, 32'd0);
      apply(8'h01, 1'b0);
      apply(8'h10, 1'b0);
      apply(8'h29, 1'b0);
      apply(8'h40, 1'b1);
      check(9, "address kept after idle bytes", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'h4E});
      apply(8'h30, 1'b1);
      check(9, "pending kept after idle bytes", {23'd0, wr_stb, wr_data}, {23'd0, 1'b1, 8'h01});

      // R1: reset in the middle of a stream clears address and pending nibble
      apply(8'h2B, 1'b1);
      apply(8'h05, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      apply(8'h30, 1'b1);
      check(1, "write after mid reset", {15'd0, wr_stb, wr_addr, wr_data}, {15'd0, 1'b1, 8'h00, 8'h00});
      apply(8'h40, 1'b1);
      check(1, "read at 0 after mid reset", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'hA5});
      check(4, "read valid is one cycle", 32'(rd_valid), 32'd1);
      @(negedge clk);
      check(4, "read valid drops", 32'(rd_valid), 32'd0);

      finish_run();
   end

   initial begin
      #(5.0 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule